// File: doc/BRIEF.md
# USB Frame and Keep-Alive Scheduler

This block is the timing source on the host side of a USB link. It decides in which clock cycle a start-of-frame token is due and which frame and microframe numbers that token carries. It also decides when a keep-alive SE0 is due on ports that run at low speed. It runs from a free-running clock whose frequency is a parameter. From that frequency it derives a 125 µs microframe period, a 1 ms frame period and a keep-alive pulse width of about 1.33 µs. Serializing the token, computing its CRC and driving the lines belong to other blocks, which consume the strobes produced here.

A mode input selects the rate of start-of-frame requests. In full-speed timing there is one request per millisecond. In high-speed timing there are eight requests per millisecond, and all eight carry the same frame number. The keep-alive schedule is 1 ms in both modes. While the enable input is low, every counter holds its value and no strobe is produced. When the enable input goes high again, counting resumes from the held values.

Top module: `usb_frame_timer`

## Requirements
- R1: With `hs_mode_i` = 0 (full-speed timing), `sof_o` is a one-cycle pulse every CLK_HZ/1000 enabled cycles, and it is always issued while `uframe_o` = 0.
- R2: With `hs_mode_i` = 1 (high-speed timing), `sof_o` is a one-cycle pulse every CLK_HZ/8000 enabled cycles, once for each microframe.
- R3: `frame_o` is an 11-bit count. It increments by one each time the microframe index passes from 7 to 0, and it wraps from 2047 to 0.
- R4: In high-speed timing, the eight requests of one frame show the same `frame_o` value, with `uframe_o` running 0, 1, ..., 7 in that order.
- R5: `uframe_o` is a 3-bit index that advances once every CLK_HZ/8000 enabled cycles in both modes. It returns to 0 in the same cycle that `frame_o` advances.
- R6: `keepalive_o` is high for KA_CYC consecutive enabled cycles once per 1 ms, in both modes. Its first high cycle coincides with the request at microframe 0. KA_CYC = round(CLK_HZ × KA_NS / 10^9), with a minimum of 1.
- R7: While `en_i` = 0, `frame_o`, `uframe_o` and the position inside the microframe hold their values, and `sof_o` and `keepalive_o` stay low. Counting resumes from the held values when `en_i` returns to 1.
- R8: After reset, `frame_o` = 0 and `uframe_o` = 0. The first enabled cycle after reset issues a request and begins a keep-alive pulse.
- R9: Changing `hs_mode_i` only changes which microframe boundaries issue a request. The frame, microframe and cycle counts continue without a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock of CLK_HZ hertz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable; low freezes the schedule and silences the strobes |
| hs_mode_i | input | 1 | 0 selects full-speed frame timing, 1 selects high-speed microframe timing |
| sof_o | output | 1 | One-cycle start-of-frame request |
| frame_o | output | 11 | Frame number to place in the token |
| uframe_o | output | 3 | Microframe index within the current frame |
| keepalive_o | output | 1 | Keep-alive SE0 request for low-speed ports, KA_CYC cycles wide |

## Verification
A reference model in the bench is checked against the design in every cycle. The stimulus includes long stretches in each timing mode, a long hold with the enable low, a mode change in the middle of a frame, and an enable pattern that toggles every few cycles. The single-mode runs confirm the request spacing and the numbering. The hold and the toggled enable show that counting pauses instead of restarting. The mode change shows that the numbering continues through the switch. A second instance with a slow clock setting runs through more than 2048 frames, so that the wrap of the frame number and the exact 1 ms spacing are both observed.

// File: rtl/usb_frm_pkg.sv
package usb_frm_pkg;

   localparam int unsigned FRAME_W      = 11;
   localparam int unsigned UF_W         = 3;
   localparam int unsigned UF_PER_FRAME = 8;
   localparam longint      UF_PER_SEC   = 8000;

   typedef enum logic {
      SPD_FULL = 1'b0,
      SPD_HIGH = 1'b1
   } spd_mode_e;

   // Cycles in one 125 us microframe.
   function automatic int unsigned uf_cycles(longint clk_hz);
      return int'(clk_hz / UF_PER_SEC);
   endfunction

   // Keep-alive width in cycles, rounded to nearest, never below one.
   function automatic int unsigned ka_cycles(longint clk_hz, longint ka_ns);
      longint w;
      w = (clk_hz * ka_ns + 64'd500_000_000) / 64'd1_000_000_000;
      if (w < 1) w = 1;
      return int'(w);
   endfunction

endpackage

// File: rtl/usb_frm_tick.sv
module usb_frm_tick #(
   parameter int unsigned MF_CYC = 375,
   localparam int unsigned CW    = $clog2(MF_CYC)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   output logic [CW-1:0] cnt_o,
   output logic          mf_start_o,
   output logic          mf_last_o
);

   logic [CW-1:0] cnt_q;

   assign mf_last_o  = (cnt_q == CW'(MF_CYC - 1));
   assign mf_start_o = (cnt_q == '0);
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= mf_last_o ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: the cycle after a microframe end starts the next microframe
   assert_mf_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && mf_last_o) |=> (cnt_o == '0));

endmodule

// File: rtl/usb_frm_count.sv
module usb_frm_count
   import usb_frm_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               adv_i,
   output logic [UF_W-1:0]    uf_o,
   output logic [FRAME_W-1:0] frame_o
);

   logic [UF_W-1:0]    uf_q;
   logic [FRAME_W-1:0] frame_q;
   logic               uf_top;

   assign uf_top  = (uf_q == UF_W'(UF_PER_FRAME - 1));
   assign uf_o    = uf_q;
   assign frame_o = frame_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         uf_q    <= '0;
         frame_q <= '0;
      end else if (adv_i) begin
         uf_q <= uf_top ? '0 : uf_q + 1'b1;
         if (uf_top) begin
            frame_q <= frame_q + 1'b1;
         end
      end
   end

   assert_frame_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_q != $past(frame_q)) |-> (frame_q == $past(frame_q) + 11'd1));

   assert_uf_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_q != $past(frame_q)) |-> (uf_q == '0));

   assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> ($stable(frame_q) && $stable(uf_q)));

endmodule

// File: rtl/usb_frm_keepalive.sv
module usb_frm_keepalive #(
   parameter int unsigned MF_CYC = 375,
   parameter int unsigned KA_CYC = 4,
   localparam int unsigned CW    = $clog2(MF_CYC)
) (
   input  logic          en_i,
   input  logic          uf_zero_i,
   input  logic [CW-1:0] cnt_i,
   output logic          ka_o
);

   if (KA_CYC == 1) begin : g_single
      assign ka_o = en_i && uf_zero_i && (cnt_i == '0);
   end else begin : g_window
      assign ka_o = en_i && uf_zero_i && (cnt_i < CW'(KA_CYC));
   end

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
   import usb_frm_pkg::*;
#(
   parameter longint CLK_HZ = 48_000_000,
   parameter longint KA_NS  = 1333,
   localparam int unsigned MF_CYC = uf_cycles(CLK_HZ),
   localparam int unsigned KA_CYC = ka_cycles(CLK_HZ, KA_NS),
   localparam int unsigned CW     = $clog2(MF_CYC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               hs_mode_i,
   output logic               sof_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic [UF_W-1:0]    uframe_o,
   output logic               keepalive_o
);

   if (CLK_HZ % UF_PER_SEC != 0) begin : g_chk_div
      $error("CLK_HZ must be a multiple of 8000");
   end
   if (MF_CYC < 2) begin : g_chk_min
      $error("CLK_HZ too low for a 125 us microframe");
   end
   if (KA_CYC >= MF_CYC) begin : g_chk_ka
      $error("keep-alive width must be shorter than a microframe");
   end

   spd_mode_e     mode;
   logic [CW-1:0] cnt;
   logic          mf_start;
   logic          mf_last;
   logic          uf_zero;

   assign mode = spd_mode_e'(hs_mode_i);

   usb_frm_tick #(.MF_CYC(MF_CYC)) u_tick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .cnt_o      (cnt),
      .mf_start_o (mf_start),
      .mf_last_o  (mf_last)
   );

   usb_frm_count u_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (en_i && mf_last),
      .uf_o    (uframe_o),
      .frame_o (frame_o)
   );

   assign uf_zero = (uframe_o == '0);

   usb_frm_keepalive #(.MF_CYC(MF_CYC), .KA_CYC(KA_CYC)) u_ka (
      .en_i      (en_i),
      .uf_zero_i (uf_zero),
      .cnt_i     (cnt),
      .ka_o      (keepalive_o)
   );

   always_comb begin
      sof_o = 1'b0;
      if (en_i && mf_start) begin
         unique case (mode)
            SPD_HIGH: sof_o = 1'b1;
            SPD_FULL: sof_o = uf_zero;
            default:  sof_o = 1'b0;
         endcase
      end
   end

   // R6: a fresh keep-alive pulse always starts together with a request
   assert_ka_with_sof_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(keepalive_o) && $past(en_i)) |-> sof_o);

   // R4: later microframe requests keep the frame number
   assert_frame_shared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sof_o && hs_mode_i && uframe_o != '0) |-> $stable(frame_o));

endmodule

// File: tb/usb_frame_timer_tb_top.sv
module usb_frame_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam longint HZ_A = 3_000_000;
   localparam int MF_A = 375;
   localparam int KA_A = 4;
   localparam longint HZ_W = 64_000;
   localparam int MS_W = 64;

   typedef struct {
      logic [10:0] fr;
      logic [2:0]  uf;
   } sof_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic hs = 1'b0;
   logic sof, ka, sof_w, ka_w;
   logic [10:0] frame, frame_w;
   logic [2:0]  uframe, uframe_w;

   int n_chk = 0;
   int n_bad = 0;
   longint cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   usb_frame_timer #(.CLK_HZ(HZ_A)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hs_mode_i(hs),
      .sof_o(sof), .frame_o(frame), .uframe_o(uframe), .keepalive_o(ka)
   );

   usb_frame_timer #(.CLK_HZ(HZ_W)) dut_wrap_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(rst_n), .hs_mode_i(1'b0),
      .sof_o(sof_w), .frame_o(frame_w), .uframe_o(uframe_w), .keepalive_o(ka_w)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // reference model state
   int          m_cnt = 0;
   int          m_uf = 0;
   int          m_fr = 0;
   sof_t        exp_q[$];

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_cnt = 0; m_uf = 0; m_fr = 0;
      end else if (en) begin
         if (m_cnt == MF_A - 1) begin
            m_cnt = 0;
            if (m_uf == 7) begin
               m_uf = 0;
               m_fr = (m_fr + 1) % 2048;
            end else begin
               m_uf = m_uf + 1;
            end
         end else begin
            m_cnt = m_cnt + 1;
         end
      end
   end

   // scoreboard monitor for the main instance
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_ka;
         sof_t e;
         if (en && m_cnt == 0 && (hs || m_uf == 0)) begin
            e.fr = 11'(m_fr);
            e.uf = 3'(m_uf);
            exp_q.push_back(e);
         end
         exp_ka = en && m_uf == 0 && m_cnt < KA_A;
         check(ka == exp_ka, "R6 R7", "keepalive_o", ka, exp_ka);
         check(frame == 11'(m_fr), "R3 R9", "frame_o", frame, m_fr);
         check(uframe == 3'(m_uf), "R5 R9", "uframe_o", uframe, m_uf);
         if (sof) begin
            if (exp_q.size() == 0) begin
               check(1'b0, hs ? "R2" : "R1 R7", "unexpected sof_o", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(frame == e.fr, hs ? "R4" : "R1", "sof frame", frame, e.fr);
               check(uframe == e.uf, hs ? "R4" : "R1", "sof uframe", uframe, e.uf);
            end
         end
         if (exp_q.size() != 0) begin
            check(1'b0, hs ? "R2" : "R1", "missing sof_o", 0, 1);
            exp_q.delete();
         end
      end
   end

   // wrap instance monitor: 1 ms spacing and frame number wrap
   int     w_exp = 0;
   int     w_cnt = 0;
   longint w_last = 0;
   bit     wrap_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sof_w && !wrap_done) begin
         check(frame_w == 11'(w_exp), "R3", "wrap frame_o", frame_w, w_exp);
         check(uframe_w == 3'd0, "R1", "wrap uframe_o", uframe_w, 0);
         if (w_cnt > 0) check(cyc - w_last == MS_W, "R1", "sof spacing", cyc - w_last, MS_W);
         w_last = cyc;
         w_exp = (w_exp + 1) % 2048;
         w_cnt++;
         if (w_cnt == 2052) wrap_done = 1'b1;
      end
   end

   task automatic run(input logic e, input logic h, input int n);
      en = e;
      hs = h;
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [10:0] f_hold;
      logic [2:0]  u_hold;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(frame == 0, "R8", "reset frame_o", frame, 0);
      check(uframe == 0, "R8", "reset uframe_o", uframe, 0);
      check(sof == 0, "R8", "reset sof_o", sof, 0);
      check(ka == 0, "R8", "reset keepalive_o", ka, 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      en = 1'b1;
      hs = 1'b0;
      @(negedge clk);
      check(sof == 1, "R8", "first sof_o", sof, 1);
      check(ka == 1, "R8", "first keepalive_o", ka, 1);
      @(posedge clk);
      #1;
      run(1'b1, 1'b0, 9000);             // full-speed, R1
      run(1'b1, 1'b1, 9000);             // high-speed, R2 R4
      run(1'b1, 1'b1, 200);
      f_hold = frame;
      u_hold = uframe;
      run(1'b0, 1'b1, 1000);             // R7 hold
      check(frame == f_hold, "R7", "held frame_o", frame, f_hold);
      check(uframe == u_hold, "R7", "held uframe_o", uframe, u_hold);
      run(1'b1, 1'b1, 1100);
      run(1'b1, 1'b0, 6000);             // R9 switch mid-frame
      run(1'b1, 1'b1, 2500);
      for (int i = 0; i < 3000; i++) begin
         en = (i % 3) != 0;
         hs = (i / 1500) == 0;
         @(posedge clk);
         #1;
      end
      en = 1'b1;
      wait (wrap_done);
      @(negedge clk);
      check(w_cnt == 2052, "R3", "wrap sof count", w_cnt, 2052);
      finish_run();
   end

endmodule